// File: doc/BRIEF.md
# Pipelined Multiply-Adder

This block multiplies up to four operand pairs and merges the products into one result. Each odd-numbered product can be added to or subtracted from its even-numbered partner under a runtime control bit, and the two pair sums are then added. A second runtime bit picks whether the operands are two's complement or unsigned. Both control bits travel down the pipeline with the operands they were sampled with, so a caller may change them on every cycle.

Register stages on the inputs and on the products are chosen by parameters. A result register is always present and can be followed by any number of extra latency registers. A valid flag runs alongside the data. A parameter selects a shift-chain mode. In that mode the A operand register of each multiplier loads from the A register of the multiplier below it, which forms the delay line of a tapped filter. One clock enable stalls every stage. A synchronous clear empties every stage.

Top module: `mult_add_pipe`

## Requirements
- R1: After reset is released, `result_o` is 0 and `valid_o` is 0.
- R2: `result_o` equals p0 ± p1 + p2 ± p3, where pk is the product of operand slice k of `a_i` and slice k of `b_i` (bits k*WIDTH and up). Products with k not below NUM_MULT are absent. The result appears LATENCY = IN_REG + PROD_REG + 1 + EXTRA_LAT enabled cycles after the operands are sampled, which is 4 with the default parameters. The sum is taken modulo 2^RES_W.
- R3: When `sign_i` is 1, every operand is read as two's complement and products are sign-extended. When it is 0, operands are unsigned and products are zero-extended. The bit always applies to the operands sampled in the same cycle.
- R4: When `sub_i[0]` is 1, p1 is subtracted instead of added. When `sub_i[1]` is 1, the same holds for p3. Each bit applies to the operands sampled in the same cycle.
- R5: RES_W is 2*WIDTH + ceil(log2(NUM_MULT)). An unsigned sum of additions never overflows, even with every operand at its maximum.
- R6: `valid_o` equals `valid_i` delayed by LATENCY enabled cycles.
- R7: While `en_i` is 0, no stage changes, so `result_o` and `valid_o` hold. When `en_i` returns to 1, the stalled data resumes from the stage where it stopped.
- R8: `clr_i` zeroes every stage, including the held control bits and the valid flags, at the next clock edge. It does so even while `en_i` is 0.
- R9: With SHIFT_CHAIN set, slice 0 of `a_i` feeds the A register of multiplier 0. Multiplier k takes its A from the A register of multiplier k-1, so it sees slice 0 delayed by k further cycles. Slices of `a_i` above 0 are ignored. `b_i` is used as in R2, and the input register is always present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all stages |
| clr_i | input | 1 | Synchronous clear of all stages |
| valid_i | input | 1 | Operands valid |
| sign_i | input | 1 | 1: signed operands, 0: unsigned |
| sub_i | input | 2 | Bit 0: subtract p1; bit 1: subtract p3 |
| a_i | input | NUM_MULT*WIDTH | A operands, slice k for multiplier k |
| b_i | input | NUM_MULT*WIDTH | B operands, slice k for multiplier k |
| result_o | output | RES_W | Sum of products |
| valid_o | output | 1 | Result valid |

## Verification
The bound checker checks four behaviours on every cycle. Products formed in unsigned mode never reach the headroom bits. The valid flag matches a delayed copy of `valid_i`. A stall holds both outputs. A clear empties them on the next edge. The arithmetic of R2 to R5 and R9 can only be shown by the bench's scenarios, which compare against a software model. These include streams whose sign and subtract bits flip on every cycle, which would expose a control bit that is one stage out of step with its data. The same holds for the resumption after a stall, which is R7.

// File: rtl/mult_add_pkg.sv
package mult_add_pkg;
  typedef struct packed {
    logic       sign;
    logic [1:0] sub;
    logic       vld;
  } ma_ctrl_t;
  localparam int unsigned CTRL_W = $bits(ma_ctrl_t);
endpackage

// File: rtl/ma_pipe_reg.sv
module ma_pipe_reg #(
  parameter int unsigned DW = 1,
  parameter bit          EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (clr_i)  q_o <= '0;  // clear wins over enable
      else if (en_i)   q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/ma_input_stage.sv
module ma_input_stage
  import mult_add_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NUM_MULT = 4,
  parameter bit          REG = 1'b1,
  parameter bit          SHIFT_CHAIN = 1'b0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           clr_i,
  input  logic [NUM_MULT-1:0][WIDTH-1:0] a_i,
  input  logic [NUM_MULT-1:0][WIDTH-1:0] b_i,
  input  ma_ctrl_t                       ctrl_i,
  output logic [NUM_MULT-1:0][WIDTH-1:0] a_o,
  output logic [NUM_MULT-1:0][WIDTH-1:0] b_o,
  output ma_ctrl_t                       ctrl_o
);
  for (genvar k = 0; k < NUM_MULT; k++) begin : g_lane
    logic [WIDTH-1:0] a_src;
    if (SHIFT_CHAIN && k > 0) begin : g_chain
      assign a_src = a_o[k-1];
    end else begin : g_ext
      assign a_src = a_i[k];
    end
    ma_pipe_reg #(.DW(WIDTH), .EN(REG)) u_a (
      .clk_i, .rst_ni, .en_i, .clr_i, .d_i(a_src), .q_o(a_o[k]));
    ma_pipe_reg #(.DW(WIDTH), .EN(REG)) u_b (
      .clk_i, .rst_ni, .en_i, .clr_i, .d_i(b_i[k]), .q_o(b_o[k]));
  end

  ma_pipe_reg #(.DW(CTRL_W), .EN(REG)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .clr_i, .d_i(ctrl_i), .q_o(ctrl_o));
endmodule

// File: rtl/ma_prod_stage.sv
module ma_prod_stage
  import mult_add_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NUM_MULT = 4,
  parameter int unsigned RES_W = 18,
  parameter bit          REG = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           clr_i,
  input  logic [NUM_MULT-1:0][WIDTH-1:0] a_i,
  input  logic [NUM_MULT-1:0][WIDTH-1:0] b_i,
  input  ma_ctrl_t                       ctrl_i,
  output logic [NUM_MULT-1:0][RES_W-1:0] prod_o,
  output ma_ctrl_t                       ctrl_o
);
  localparam int unsigned PW = 2*WIDTH + 2;

  logic [NUM_MULT-1:0][RES_W-1:0] prod_d;

  for (genvar k = 0; k < NUM_MULT; k++) begin : g_mul
    logic signed [WIDTH:0] ax, bx;
    logic signed [PW-1:0]  p;
    // one extra bit turns unsigned operands into non-negative signed ones
    assign ax = {ctrl_i.sign & a_i[k][WIDTH-1], a_i[k]};
    assign bx = {ctrl_i.sign & b_i[k][WIDTH-1], b_i[k]};
    assign p  = ax * bx;
    assign prod_d[k] = p[RES_W-1:0];
  end

  ma_pipe_reg #(.DW(NUM_MULT*RES_W), .EN(REG)) u_prod (
    .clk_i, .rst_ni, .en_i, .clr_i, .d_i(prod_d), .q_o(prod_o));
  ma_pipe_reg #(.DW(CTRL_W), .EN(REG)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .clr_i, .d_i(ctrl_i), .q_o(ctrl_o));
endmodule

// File: rtl/ma_sum_stage.sv
module ma_sum_stage
  import mult_add_pkg::*;
#(
  parameter int unsigned NUM_MULT = 4,
  parameter int unsigned RES_W = 18,
  parameter int unsigned EXTRA_LAT = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           clr_i,
  input  logic [NUM_MULT-1:0][RES_W-1:0] prod_i,
  input  ma_ctrl_t                       ctrl_i,
  output logic [RES_W-1:0]               result_o,
  output logic                           valid_o
);
  logic [RES_W-1:0] acc;
  logic [RES_W:0]   chain [EXTRA_LAT+1];

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_MULT; k++) begin
      if ((k % 2 == 1) && ctrl_i.sub[k/2]) acc = acc - prod_i[k];
      else                                 acc = acc + prod_i[k];
    end
  end

  ma_pipe_reg #(.DW(RES_W+1), .EN(1'b1)) u_res (
    .clk_i, .rst_ni, .en_i, .clr_i, .d_i({ctrl_i.vld, acc}), .q_o(chain[0]));

  for (genvar i = 0; i < EXTRA_LAT; i++) begin : g_lat
    ma_pipe_reg #(.DW(RES_W+1), .EN(1'b1)) u_lat (
      .clk_i, .rst_ni, .en_i, .clr_i, .d_i(chain[i]), .q_o(chain[i+1]));
  end

  assign {valid_o, result_o} = chain[EXTRA_LAT];
endmodule

// File: rtl/mult_add_pipe.sv
module mult_add_pipe
  import mult_add_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned NUM_MULT    = 4,
  parameter bit          IN_REG      = 1'b1,
  parameter bit          PROD_REG    = 1'b1,
  parameter int unsigned EXTRA_LAT   = 1,
  parameter bit          SHIFT_CHAIN = 1'b0,
  localparam int unsigned RES_W = 2*WIDTH + $clog2(NUM_MULT)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      clr_i,
  input  logic                      valid_i,
  input  logic                      sign_i,
  input  logic [1:0]                sub_i,
  input  logic [NUM_MULT*WIDTH-1:0] a_i,
  input  logic [NUM_MULT*WIDTH-1:0] b_i,
  output logic [RES_W-1:0]          result_o,
  output logic                      valid_o
);
  // shift chain needs the A registers
  localparam bit IN_EFF = IN_REG | SHIFT_CHAIN;

  logic [NUM_MULT-1:0][WIDTH-1:0] a_arr, b_arr, a_q, b_q;
  logic [NUM_MULT-1:0][RES_W-1:0] prod_q;
  ma_ctrl_t ctrl_in, in_ctrl, prod_ctrl;

  assign a_arr   = a_i;
  assign b_arr   = b_i;
  assign ctrl_in = '{sign: sign_i, sub: sub_i, vld: valid_i};

  ma_input_stage #(
    .WIDTH(WIDTH), .NUM_MULT(NUM_MULT), .REG(IN_EFF), .SHIFT_CHAIN(SHIFT_CHAIN)
  ) u_in (
    .clk_i, .rst_ni, .en_i, .clr_i,
    .a_i(a_arr), .b_i(b_arr), .ctrl_i(ctrl_in),
    .a_o(a_q), .b_o(b_q), .ctrl_o(in_ctrl));

  ma_prod_stage #(
    .WIDTH(WIDTH), .NUM_MULT(NUM_MULT), .RES_W(RES_W), .REG(PROD_REG)
  ) u_prod (
    .clk_i, .rst_ni, .en_i, .clr_i,
    .a_i(a_q), .b_i(b_q), .ctrl_i(in_ctrl),
    .prod_o(prod_q), .ctrl_o(prod_ctrl));

  ma_sum_stage #(
    .NUM_MULT(NUM_MULT), .RES_W(RES_W), .EXTRA_LAT(EXTRA_LAT)
  ) u_sum (
    .clk_i, .rst_ni, .en_i, .clr_i,
    .prod_i(prod_q), .ctrl_i(prod_ctrl),
    .result_o, .valid_o);
endmodule

// File: rtl/mult_add_pipe_chk.sv
module mult_add_pipe_chk
  import mult_add_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned NUM_MULT = 4,
  parameter int unsigned RES_W    = 18,
  parameter int unsigned LATENCY  = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           en_i,
  input logic                           clr_i,
  input logic                           valid_i,
  input logic [RES_W-1:0]               result_o,
  input logic                           valid_o,
  input ma_ctrl_t                       prod_ctrl,
  input logic [NUM_MULT-1:0][RES_W-1:0] prod_q
);
  logic [LATENCY-1:0] vld_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_sh <= '0;
    else if (clr_i)  vld_sh <= '0;
    else if (en_i)   vld_sh <= (vld_sh << 1) | LATENCY'(valid_i);
  end

  p_valid_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vld_sh[LATENCY-1]);

  p_en_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(result_o) && $stable(valid_o)));

  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (result_o == '0 && !valid_o));

  if (RES_W > 2*WIDTH) begin : g_head
    for (genvar k = 0; k < NUM_MULT; k++) begin : g_p
      // R5: unsigned products leave the headroom bits clear
      p_unsigned_prod_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !prod_ctrl.sign |-> (prod_q[k][RES_W-1:2*WIDTH] == '0));
    end
  end
endmodule

bind mult_add_pipe mult_add_pipe_chk #(
  .WIDTH(WIDTH), .NUM_MULT(NUM_MULT), .RES_W(RES_W),
  .LATENCY(IN_EFF + PROD_REG + 1 + EXTRA_LAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clr_i(clr_i),
  .valid_i(valid_i), .result_o(result_o), .valid_o(valid_o),
  .prod_ctrl(prod_ctrl), .prod_q(prod_q));

// File: tb/sim_mult_add_pipe.sv
`timescale 1ns/1ps
module sim_mult_add_pipe;
  localparam int W = 8;
  localparam int N = 4;
  localparam int RW = 2*W + 2;
  localparam int LAT0 = 4;
  localparam int LAT1 = 2;
  localparam int HMAX = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, clr = 1'b0, vld = 1'b0, sgn = 1'b0;
  logic [1:0] sub = '0;
  logic [N*W-1:0] a = '0, b = '0;
  logic [RW-1:0] res0, res1;
  logic vo0, vo1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [N*W-1:0] ha [HMAX];
  logic [N*W-1:0] hb [HMAX];
  logic           hs [HMAX];
  logic [1:0]     hsub [HMAX];
  logic           hv [HMAX];

  always #10 clk = ~clk;

  mult_add_pipe #(.WIDTH(W), .NUM_MULT(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .valid_i(vld),
    .sign_i(sgn), .sub_i(sub), .a_i(a), .b_i(b), .result_o(res0), .valid_o(vo0));

  mult_add_pipe #(.WIDTH(W), .NUM_MULT(N), .PROD_REG(1'b0), .EXTRA_LAT(0),
                  .SHIFT_CHAIN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .valid_i(vld),
    .sign_i(sgn), .sub_i(sub), .a_i(a), .b_i(b), .result_o(res1), .valid_o(vo1));

  function automatic logic [RW-1:0] model(logic [N*W-1:0] av, logic [N*W-1:0] bv,
                                          logic sg, logic [1:0] sb);
    longint acc = 0;
    for (int m = 0; m < N; m++) begin
      longint x, y;
      x = sg ? longint'($signed(av[m*W +: W])) : longint'(av[m*W +: W]);
      y = sg ? longint'($signed(bv[m*W +: W])) : longint'(bv[m*W +: W]);
      if ((m == 1 && sb[0]) || (m == 3 && sb[1])) acc -= x * y;
      else acc += x * y;
    end
    return acc[RW-1:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; vld = 1'b0; a = '0; b = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // mode 0: random, controls random; 1: random, controls flip each cycle; 2: extremes
  task automatic t_stream(int n, int mode, string tag);
    do_clear();
    for (int k = 0; k < n + LAT0; k++) begin
      int j0, j1;
      if (k > 0) @(negedge clk);
      j0 = k - LAT0;
      j1 = k - LAT1;
      if (j0 >= 0) begin
        chk({tag, " u0 result"}, 64'(res0), 64'(model(ha[j0], hb[j0], hs[j0], hsub[j0])));
        chk("R6 u0 valid", 64'(vo0), 64'(hv[j0]));
      end else begin
        chk("R8 u0 empty after clear", 64'({vo0, res0}), 64'(0));
      end
      if (j1 >= 0 && j1 < n) begin
        logic [N*W-1:0] ac;
        for (int m = 0; m < N; m++) ac[m*W +: W] = (j1 - m >= 0) ? ha[j1-m][W-1:0] : '0;
        chk("R9 u1 chain result", 64'(res1), 64'(model(ac, hb[j1], hs[j1], hsub[j1])));
        chk("R9 u1 valid", 64'(vo1), 64'(hv[j1]));
      end
      if (k < n) begin
        case (mode)
          0: begin a = {$urandom, $urandom}; b = {$urandom, $urandom};
                   sgn = $urandom; sub = $urandom; end
          1: begin a = $urandom; b = $urandom; sgn = k[0]; sub = {k[1], ~k[0]}; end
          default: begin
            a = k[0] ? {N{8'h80}} : {N{8'hFF}};
            b = k[1] ? {N{8'h80}} : {N{8'hFF}};
            sgn = k[2]; sub = k[3] ? 2'b11 : 2'b00;
          end
        endcase
        vld = $urandom;
      end else begin
        a = '0; b = '0; vld = 1'b0; sgn = 1'b0; sub = '0;
      end
      ha[k % HMAX] = a; hb[k % HMAX] = b; hs[k % HMAX] = sgn;
      hsub[k % HMAX] = sub; hv[k % HMAX] = vld;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 u0 reset", 64'({vo0, res0}), 64'(0));
    chk("R1 u1 reset", 64'({vo1, res1}), 64'(0));
  endtask

  task automatic t_max_unsigned();
    logic [RW-1:0] exp;
    do_clear();
    a = {N{8'hFF}}; b = {N{8'hFF}}; sgn = 1'b0; sub = 2'b00; vld = 1'b1;
    exp = RW'(4 * 255 * 255);  // 260100 fits 18 bits
    @(negedge clk);
    vld = 1'b0; a = '0; b = '0;
    repeat (LAT0 - 1) @(negedge clk);
    chk("R5 unsigned max no overflow", 64'(res0), 64'(exp));
    chk("R5 max valid", 64'(vo0), 64'(1));
  endtask

  task automatic t_sub_signed();
    do_clear();
    // signed: 3*4 - (-2*5) + (-7*-7) - (127*-128) = 12+10+49+16256
    a = {8'd127, 8'hF9, 8'hFE, 8'd3}; b = {8'h80, 8'hF9, 8'd5, 8'd4};
    sgn = 1'b1; sub = 2'b11; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; sgn = 1'b0; sub = 2'b00; a = '0; b = '0;
    repeat (LAT0 - 1) @(negedge clk);
    chk("R4 R3 signed subtract", 64'(res0), 64'(RW'(16327)));
  endtask

  task automatic t_enable();
    logic [N*W-1:0] xa, xb;
    logic [RW-1:0] exp;
    do_clear();
    xa = {8'd9, 8'd200, 8'd17, 8'd33}; xb = {8'd2, 8'd3, 8'd250, 8'd6};
    exp = model(xa, xb, 1'b0, 2'b01);
    a = xa; b = xb; sgn = 1'b0; sub = 2'b01; vld = 1'b1;
    @(negedge clk);
    en = 1'b0; a = '1; b = '1; sgn = 1'b1; sub = 2'b10;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 stalled output held", 64'({vo0, res0}), 64'(0));
    end
    en = 1'b1; a = '0; b = '0; vld = 1'b0; sgn = 1'b0; sub = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 not yet out", 64'(vo0), 64'(0));
    @(negedge clk);
    chk("R7 resumed result", 64'(res0), 64'(exp));
    chk("R7 resumed valid", 64'(vo0), 64'(1));
  endtask

  task automatic t_clear();
    do_clear();
    a = {N{8'h55}}; b = {N{8'h33}}; vld = 1'b1; sgn = 1'b1; sub = 2'b11;
    repeat (5) @(negedge clk);
    chk("R8 loaded before clear", 64'(vo0), 64'(1));
    clr = 1'b1; en = 1'b0;
    @(negedge clk);
    clr = 1'b0; en = 1'b1; vld = 1'b0; a = '0; b = '0; sgn = 1'b0; sub = '0;
    chk("R8 cleared while stalled", 64'({vo0, res0}), 64'(0));
    for (int i = 0; i < LAT0; i++) begin
      @(negedge clk);
      chk("R8 stages empty", 64'({vo0, res0}), 64'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream(150, 0, "R2");
    t_stream(120, 1, "R3 R4 aligned");
    t_stream(40, 2, "R5 extremes");
    t_max_unsigned();
    t_sub_signed();
    t_enable();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule